// File: doc/BRIEF.md
# Hypervisor Feature Trap Controller

This block holds one 32-bit hypervisor control word. The word decides whether non-secure software may reach coprocessor 10, coprocessor 11, the SIMD functionality and the coprocessor access control register, or whether such uses are diverted. The register sits on a system-register port. A read or write names an encoding and carries the privilege level and the security flag of the requester. The block claims only its own encoding. It answers with read data, or with an undefined-access response when the requester may not touch it.

A second input group carries three disable bits from the secure-side access control register. When one of these bits forbids non-secure use of a feature, the matching trap bit acts as 1. It also reads back as 1. A separate request port describes one feature use at a time: the feature, the privilege level, the security state, and whether the use is otherwise valid. The block classifies each request combinationally as allow, trap to the hypervisor, or undefined instruction in hypervisor mode. Exception entry is left to the surrounding pipeline.

Top module: `hyp_trap_ctl`

## Requirements
- R1: The register responds (`sr_hit`=1) only when `sr_req`=1 and the encoding is coprocessor 15, opc1=4, CRn=1, CRm=1, opc2=2. Any other encoding gives `sr_hit`=0, `sr_undef`=0 and `sr_rdata`=0, and a write to it changes nothing.
- R2: Access to the register is granted only at level 2 (hypervisor) or at level 3 with `sr_ns`=1. Level encodings are 0 user, 1 kernel, 2 hypervisor and 3 highest. Any other requester gets `sr_undef`=1 and `sr_rdata`=0, and its write has no effect.
- R3: After reset the four control bits are 0. A granted read returns 0x000033FF when no disable input is set.
- R4: Only bit 31 (access-control-register trap), bit 15 (SIMD trap), bit 11 (coprocessor 11 trap) and bit 10 (coprocessor 10 trap) are writable. Bits 13:12 and 9:0 always read 1, and every other bit reads 0. A granted write is visible on reads from the cycle after the clock edge that captures it. A read made while the write is still pending shows the old value.
- R5: `sec_simd_dis`, `sec_cp10_dis` and `sec_cp11_dis` force bit 15, bit 10 and bit 11 respectively to 1. This applies both to read-back and to classification, and the stored bits are left unchanged.
- R6: `fq_cls` is always one-hot. Bit 0 means allow, bit 1 means trap to the hypervisor, and bit 2 means undefined in hypervisor mode. Feature codes on `fq_feat` are 0 coprocessor 10, 1 coprocessor 11, 2 SIMD and 3 access control register.
- R7: If a feature of code 0, 1 or 2 has an effective trap bit of 1, a valid, otherwise-valid, non-secure request from level 0 or 1 is classified as trap.
- R8: Under the same condition, a request from level 2 is classified as undefined. Level 2 never yields trap, and levels 0, 1 and 3 never yield undefined.
- R9: When the effective coprocessor 10 and coprocessor 11 trap bits are both 1, SIMD requests are classified as if the SIMD trap bit were 1.
- R10: When bit 31 is 1, a qualifying request for feature 3 is classified as trap only if it comes from level 1. It is allowed at every other level.
- R11: A request is classified as allow in each of these cases: `fq_valid`=0, `fq_ok`=0, `fq_ns`=0, level 3, or no effective trap bit applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sr_req | input | 1 | System-register access strobe |
| sr_wr | input | 1 | 1 for a write, 0 for a read |
| sr_cp | input | 4 | Coprocessor number of the access |
| sr_opc1 | input | 3 | First opcode field |
| sr_crn | input | 4 | Primary register field |
| sr_crm | input | 4 | Secondary register field |
| sr_opc2 | input | 3 | Second opcode field |
| sr_el | input | 2 | Requester privilege level |
| sr_ns | input | 1 | Requester non-secure flag |
| sr_wdata | input | 32 | Write data |
| sr_rdata | output | 32 | Read data, zero unless a granted hit |
| sr_undef | output | 1 | Undefined-access response |
| sr_hit | output | 1 | Encoding matched this register |
| sec_simd_dis | input | 1 | Secure side forbids non-secure SIMD |
| sec_cp10_dis | input | 1 | Secure side forbids non-secure coprocessor 10 |
| sec_cp11_dis | input | 1 | Secure side forbids non-secure coprocessor 11 |
| fq_valid | input | 1 | Feature request present |
| fq_feat | input | 2 | Feature code |
| fq_el | input | 2 | Request privilege level |
| fq_ns | input | 1 | Request is non-secure |
| fq_ok | input | 1 | Request is otherwise valid |
| fq_cls | output | 3 | One-hot classification |

## Verification
The assertions assume that the secure-side disable inputs and the request fields are stable between clock edges. They also assume that a hypervisor-level request is always non-secure, because a secure level-2 request would be classified as allow and is never produced. The bench drives every input on the falling edge, so each value holds across the rising edge. It sweeps all feature, level and security combinations only together with register values that were first written through the granted path.

// File: rtl/hyp_trap_pkg.sv
package hyp_trap_pkg;
  localparam int REG_W  = 32;
  localparam int B_ACR  = 31;
  localparam int B_SIMD = 15;
  localparam int B_CP11 = 11;
  localparam int B_CP10 = 10;
  localparam int LVL_W  = 2;
  localparam int FEAT_W = 2;
  localparam int CLS_W  = 3;
  localparam int NFEAT  = 1 << FEAT_W;

  localparam logic [REG_W-1:0] RES1_MASK = 32'h0000_33FF;
  localparam logic [REG_W-1:0] WR_MASK =
    (REG_W'(1) << B_ACR) | (REG_W'(1) << B_SIMD) |
    (REG_W'(1) << B_CP11) | (REG_W'(1) << B_CP10);

  localparam logic [CLS_W-1:0] CLS_ALLOW = 3'b001;
  localparam logic [CLS_W-1:0] CLS_TRAP  = 3'b010;
  localparam logic [CLS_W-1:0] CLS_UNDEF = 3'b100;

  typedef enum logic [FEAT_W-1:0] {
    FEAT_CP10 = 2'd0,
    FEAT_CP11 = 2'd1,
    FEAT_SIMD = 2'd2,
    FEAT_ACR  = 2'd3
  } feat_e;

  typedef enum logic [LVL_W-1:0] {
    LVL_USER = 2'd0,
    LVL_KERN = 2'd1,
    LVL_HYP  = 2'd2,
    LVL_TOP  = 2'd3
  } lvl_e;

  typedef struct packed {
    logic acr;
    logic simd;
    logic cp11;
    logic cp10;
  } ctl_t;

  // Pull the writable bits out of a bus word.
  function automatic ctl_t ctl_from_word(logic [REG_W-1:0] w);
    ctl_t c;
    c.acr  = w[B_ACR];
    c.simd = w[B_SIMD];
    c.cp11 = w[B_CP11];
    c.cp10 = w[B_CP10];
    return c;
  endfunction

  // Secure-side disables force the matching trap bits high.
  function automatic ctl_t merge_dis(ctl_t raw, logic ds, logic d10, logic d11);
    ctl_t c;
    c.acr  = raw.acr;
    c.simd = raw.simd | ds;
    c.cp10 = raw.cp10 | d10;
    c.cp11 = raw.cp11 | d11;
    return c;
  endfunction

  // Architectural read view: fixed ones plus the effective control bits.
  function automatic logic [REG_W-1:0] word_view(ctl_t c);
    logic [REG_W-1:0] w;
    w = RES1_MASK;
    w[B_ACR]  = c.acr;
    w[B_SIMD] = c.simd;
    w[B_CP11] = c.cp11;
    w[B_CP10] = c.cp10;
    return w;
  endfunction

  // Which requester may reach the register.
  function automatic logic lvl_grant(lvl_e l, logic ns);
    return (l == LVL_HYP) || ((l == LVL_TOP) && ns);
  endfunction

  // Effective trap flag per feature, SIMD also caught by the coprocessor pair.
  function automatic logic feat_trap(feat_e f, ctl_t e);
    logic t;
    case (f)
      FEAT_CP10: t = e.cp10;
      FEAT_CP11: t = e.cp11;
      FEAT_SIMD: t = e.simd | (e.cp10 & e.cp11);
      default:   t = e.acr;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/hyp_trap_decode.sv
module hyp_trap_decode
  import hyp_trap_pkg::*;
#(
  parameter int          CP_W   = 4,
  parameter int          OP1_W  = 3,
  parameter int          CR_W   = 4,
  parameter int          OP2_W  = 3,
  parameter logic [3:0]  SEL_CP   = 4'd15,
  parameter logic [2:0]  SEL_OPC1 = 3'd4,
  parameter logic [3:0]  SEL_CRN  = 4'd1,
  parameter logic [3:0]  SEL_CRM  = 4'd1,
  parameter logic [2:0]  SEL_OPC2 = 3'd2
) (
  input  logic             req,
  input  logic             wr,
  input  logic [CP_W-1:0]  cp,
  input  logic [OP1_W-1:0] opc1,
  input  logic [CR_W-1:0]  crn,
  input  logic [CR_W-1:0]  crm,
  input  logic [OP2_W-1:0] opc2,
  input  logic [LVL_W-1:0] el,
  input  logic             ns,
  output logic             hit,
  output logic             granted,
  output logic             wr_fire,
  output logic             acc_undef
);
  logic enc_match;
  logic lvl_ok;

  assign enc_match = (cp == CP_W'(SEL_CP)) && (opc1 == OP1_W'(SEL_OPC1)) &&
                     (crn == CR_W'(SEL_CRN)) && (crm == CR_W'(SEL_CRM)) &&
                     (opc2 == OP2_W'(SEL_OPC2));
  assign lvl_ok    = lvl_grant(lvl_e'(el), ns);

  assign hit       = req && enc_match;
  assign granted   = hit && lvl_ok;
  assign acc_undef = hit && !lvl_ok;
  assign wr_fire   = granted && wr;
endmodule

// File: rtl/hyp_trap_store.sv
module hyp_trap_store
  import hyp_trap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_fire,
  input  ctl_t wr_ctl,
  output ctl_t raw
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw <= '0;
    end else if (wr_fire) begin
      raw <= wr_ctl;
    end
  end
endmodule

// File: rtl/hyp_trap_classify.sv
module hyp_trap_classify
  import hyp_trap_pkg::*;
(
  input  logic              fq_valid,
  input  logic [FEAT_W-1:0] fq_feat,
  input  logic [LVL_W-1:0]  fq_el,
  input  logic              fq_ns,
  input  logic              fq_ok,
  input  ctl_t              eff,
  output logic [NFEAT-1:0]  trap_vec,
  output logic              qualify,
  output logic [CLS_W-1:0]  cls
);
  lvl_e lvl;
  logic sel_trap;
  logic is_lower;

  assign lvl      = lvl_e'(fq_el);
  assign qualify  = fq_valid && fq_ok && fq_ns;
  assign is_lower = (lvl == LVL_USER) || (lvl == LVL_KERN);

  for (genvar f = 0; f < NFEAT; f++) begin : g_feat
    assign trap_vec[f] = feat_trap(feat_e'(f), eff);
  end

  assign sel_trap = trap_vec[fq_feat];

  always_comb begin
    cls = CLS_ALLOW;
    if (qualify && sel_trap) begin
      if (feat_e'(fq_feat) == FEAT_ACR) begin
        if (lvl == LVL_KERN) cls = CLS_TRAP;
      end else if (is_lower) begin
        cls = CLS_TRAP;
      end else if (lvl == LVL_HYP) begin
        cls = CLS_UNDEF;
      end
    end
  end
endmodule

// File: rtl/hyp_trap_ctl.sv
module hyp_trap_ctl
  import hyp_trap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sr_req,
  input  logic              sr_wr,
  input  logic [3:0]        sr_cp,
  input  logic [2:0]        sr_opc1,
  input  logic [3:0]        sr_crn,
  input  logic [3:0]        sr_crm,
  input  logic [2:0]        sr_opc2,
  input  logic [1:0]        sr_el,
  input  logic              sr_ns,
  input  logic [31:0]       sr_wdata,
  output logic [31:0]       sr_rdata,
  output logic              sr_undef,
  output logic              sr_hit,
  input  logic              sec_simd_dis,
  input  logic              sec_cp10_dis,
  input  logic              sec_cp11_dis,
  input  logic              fq_valid,
  input  logic [1:0]        fq_feat,
  input  logic [1:0]        fq_el,
  input  logic              fq_ns,
  input  logic              fq_ok,
  output logic [2:0]        fq_cls
);
  logic             granted;
  logic             wr_fire;
  ctl_t             wr_ctl;
  ctl_t             raw;
  ctl_t             eff;
  logic [NFEAT-1:0] trap_vec;
  logic             qualify;
  logic             unused_wbits;

  hyp_trap_decode u_dec (
    .req       (sr_req),
    .wr        (sr_wr),
    .cp        (sr_cp),
    .opc1      (sr_opc1),
    .crn       (sr_crn),
    .crm       (sr_crm),
    .opc2      (sr_opc2),
    .el        (sr_el),
    .ns        (sr_ns),
    .hit       (sr_hit),
    .granted   (granted),
    .wr_fire   (wr_fire),
    .acc_undef (sr_undef)
  );

  assign wr_ctl       = ctl_from_word(sr_wdata);
  assign unused_wbits = ^(sr_wdata & ~WR_MASK);

  hyp_trap_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .wr_ctl  (wr_ctl),
    .raw     (raw)
  );

  assign eff      = merge_dis(raw, sec_simd_dis, sec_cp10_dis, sec_cp11_dis);
  assign sr_rdata = granted ? word_view(eff) : '0;

  hyp_trap_classify u_cls (
    .fq_valid (fq_valid),
    .fq_feat  (fq_feat),
    .fq_el    (fq_el),
    .fq_ns    (fq_ns),
    .fq_ok    (fq_ok),
    .eff      (eff),
    .trap_vec (trap_vec),
    .qualify  (qualify),
    .cls      (fq_cls)
  );
endmodule

// File: rtl/hyp_trap_ctl_chk.sv
module hyp_trap_ctl_chk
  import hyp_trap_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_fire,
  input ctl_t             raw,
  input logic             sr_hit,
  input logic             sr_undef,
  input logic [31:0]      sr_rdata,
  input logic             sec_cp10_dis,
  input logic             sec_cp11_dis,
  input logic             fq_valid,
  input logic [1:0]       fq_feat,
  input logic [1:0]       fq_el,
  input logic             fq_ns,
  input logic             fq_ok,
  input logic [2:0]       fq_cls
);
  // R6
  cls_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fq_cls) == 1);

  // R2
  undef_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_undef |-> !wr_fire);

  // R4
  hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(raw));

  // R4
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_hit && !sr_undef) |-> ((sr_rdata & ~WR_MASK) == RES1_MASK));

  // R2
  undef_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_undef |-> (sr_rdata == '0));

  // R11
  secure_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fq_valid || !fq_ns || !fq_ok || fq_el == LVL_TOP) |-> (fq_cls == CLS_ALLOW));

  // R8
  hyp_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fq_el == LVL_HYP) |-> !fq_cls[1]);

  // R8
  lower_no_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fq_el != LVL_HYP) |-> !fq_cls[2]);

  // R9
  cp_pair_simd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw.cp10 || sec_cp10_dis) && (raw.cp11 || sec_cp11_dis) && fq_valid && fq_ok &&
     fq_ns && fq_feat == FEAT_SIMD && (fq_el == LVL_USER || fq_el == LVL_KERN))
    |-> (fq_cls == CLS_TRAP));
endmodule

bind hyp_trap_ctl hyp_trap_ctl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_fire      (wr_fire),
  .raw          (raw),
  .sr_hit       (sr_hit),
  .sr_undef     (sr_undef),
  .sr_rdata     (sr_rdata),
  .sec_cp10_dis (sec_cp10_dis),
  .sec_cp11_dis (sec_cp11_dis),
  .fq_valid     (fq_valid),
  .fq_feat      (fq_feat),
  .fq_el        (fq_el),
  .fq_ns        (fq_ns),
  .fq_ok        (fq_ok),
  .fq_cls       (fq_cls)
);

// File: tb/hyp_trap_ctl_bench.sv
module hyp_trap_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sr_req = 0, sr_wr = 0, sr_ns = 0;
  logic [3:0]  sr_cp = 0, sr_crn = 0, sr_crm = 0;
  logic [2:0]  sr_opc1 = 0, sr_opc2 = 0;
  logic [1:0]  sr_el = 0;
  logic [31:0] sr_wdata = 0;
  logic [31:0] sr_rdata;
  logic        sr_undef, sr_hit;
  logic        sec_simd_dis = 0, sec_cp10_dis = 0, sec_cp11_dis = 0;
  logic        fq_valid = 0, fq_ns = 0, fq_ok = 0;
  logic [1:0]  fq_feat = 0, fq_el = 0;
  logic [2:0]  fq_cls;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hyp_trap_ctl u_hyp_trap_ctl (
    .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .sr_wr(sr_wr), .sr_cp(sr_cp),
    .sr_opc1(sr_opc1), .sr_crn(sr_crn), .sr_crm(sr_crm), .sr_opc2(sr_opc2),
    .sr_el(sr_el), .sr_ns(sr_ns), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata),
    .sr_undef(sr_undef), .sr_hit(sr_hit), .sec_simd_dis(sec_simd_dis),
    .sec_cp10_dis(sec_cp10_dis), .sec_cp11_dis(sec_cp11_dis),
    .fq_valid(fq_valid), .fq_feat(fq_feat), .fq_el(fq_el), .fq_ns(fq_ns),
    .fq_ok(fq_ok), .fq_cls(fq_cls)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Model of the read view, from the requirements.
  function automatic logic [31:0] view(logic a, logic s, logic c11, logic c10);
    return 32'h0000_33FF | {a, 15'd0, s, 3'd0, c11, c10, 10'd0};
  endfunction

  // Model of the classification: 1 allow, 2 trap, 4 undef.
  function automatic logic [2:0] model_cls(int f, int el, bit ns, bit ok, bit v,
                                           bit a, bit s, bit c11, bit c10);
    bit t;
    bit e10 = c10 | sec_cp10_dis;
    bit e11 = c11 | sec_cp11_dis;
    bit es  = s | sec_simd_dis | (e10 & e11);
    if (!(v && ok && ns)) return 3'b001;
    case (f)
      0: t = e10;
      1: t = e11;
      2: t = es;
      default: t = a;
    endcase
    if (!t) return 3'b001;
    if (f == 3) return (el == 1) ? 3'b010 : 3'b001;
    if (el <= 1) return 3'b010;
    if (el == 2) return 3'b100;
    return 3'b001;
  endfunction

  task automatic set_enc(logic [3:0] cp, logic [2:0] o1, logic [3:0] n,
                         logic [3:0] m, logic [2:0] o2);
    sr_cp = cp; sr_opc1 = o1; sr_crn = n; sr_crm = m; sr_opc2 = o2;
  endtask

  task automatic reg_write(logic [31:0] d, logic [1:0] el, logic ns);
    @(negedge clk);
    sr_req = 1; sr_wr = 1; sr_wdata = d; sr_el = el; sr_ns = ns;
    @(negedge clk);
    sr_req = 0; sr_wr = 0;
  endtask

  task automatic reg_read(logic [1:0] el, logic ns,
                          output logic [31:0] d, output logic u, output logic h);
    @(negedge clk);
    sr_req = 1; sr_wr = 0; sr_el = el; sr_ns = ns;
    #1;
    d = sr_rdata; u = sr_undef; h = sr_hit;
    sr_req = 0;
  endtask

  task automatic req_cls(int f, int el, bit ns, bit ok, bit v, output logic [2:0] c);
    @(negedge clk);
    fq_feat = 2'(f); fq_el = 2'(el); fq_ns = ns; fq_ok = ok; fq_valid = v;
    #1;
    c = fq_cls;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic u, h; logic [2:0] c;
    set_enc(15, 4, 1, 1, 2);
    reg_read(2, 1, d, u, h);
    check("R3 reset read", d, 32'h0000_33FF);
    check("R1 hit", {31'd0, h}, 1);
    check("R2 hyp no undef", {31'd0, u}, 0);
    req_cls(2, 1, 1, 1, 1, c);
    check("R3 reset simd allow", {29'd0, c}, 1);
  endtask

  task automatic t_decode();
    logic [31:0] d; logic u, h;
    set_enc(15, 4, 1, 1, 3);
    reg_read(2, 1, d, u, h);
    check("R1 opc2 miss hit", {31'd0, h}, 0);
    check("R1 opc2 miss data", d, 0);
    set_enc(14, 4, 1, 1, 2);
    reg_read(2, 1, d, u, h);
    check("R1 cp miss hit/undef", {30'd0, h, u}, 0);
    reg_write(32'hFFFF_FFFF, 2, 1);
    set_enc(15, 4, 1, 1, 2);
    reg_read(2, 1, d, u, h);
    check("R1 miss write ignored", d, 32'h0000_33FF);
  endtask

  task automatic t_priv();
    logic [31:0] d; logic u, h;
    reg_read(0, 1, d, u, h);
    check("R2 user undef", {31'd0, u}, 1);
    check("R2 user data zero", d, 0);
    reg_read(1, 1, d, u, h);
    check("R2 ns kernel undef", {31'd0, u}, 1);
    reg_read(1, 0, d, u, h);
    check("R2 s kernel undef", {31'd0, u}, 1);
    reg_read(3, 0, d, u, h);
    check("R2 top secure undef", {31'd0, u}, 1);
    reg_read(3, 1, d, u, h);
    check("R2 top ns granted", {u, d[30:0]}, 32'h0000_33FF);
    reg_write(32'hFFFF_FFFF, 1, 1);
    reg_write(32'hFFFF_FFFF, 3, 0);
    reg_read(2, 1, d, u, h);
    check("R2 denied write ignored", d, 32'h0000_33FF);
  endtask

  task automatic t_write();
    logic [31:0] d; logic u, h;
    @(negedge clk);
    sr_req = 1; sr_wr = 1; sr_wdata = 32'hFFFF_FFFF; sr_el = 2; sr_ns = 1;
    #1;
    check("R4 old value before edge", sr_rdata, 32'h0000_33FF);
    @(negedge clk);
    sr_req = 0; sr_wr = 0;
    reg_read(2, 1, d, u, h);
    check("R4 all ones write", d, 32'h8000_BFFF);
    reg_write(32'h0000_0400, 3, 1);
    reg_read(2, 1, d, u, h);
    check("R4 cp10 only", d, 32'h0000_37FF);
    reg_write(32'h7FFF_73FF, 2, 1);
    reg_read(2, 1, d, u, h);
    check("R4 reserved ignored", d, 32'h0000_33FF);
  endtask

  task automatic t_merge();
    logic [31:0] d; logic u, h; logic [2:0] c;
    reg_write(0, 2, 1);
    sec_simd_dis = 1;
    reg_read(2, 1, d, u, h);
    check("R5 simd disable view", d, 32'h0000_B3FF);
    req_cls(2, 0, 1, 1, 1, c);
    check("R5 simd disable trap", {29'd0, c}, 3'b010);
    sec_simd_dis = 0; sec_cp11_dis = 1;
    reg_read(2, 1, d, u, h);
    check("R5 cp11 disable view", d, 32'h0000_3BFF);
    req_cls(1, 2, 1, 1, 1, c);
    check("R5 cp11 disable hyp undef", {29'd0, c}, 3'b100);
    sec_cp11_dis = 0; sec_cp10_dis = 1;
    reg_read(2, 1, d, u, h);
    check("R5 cp10 disable view", d, 32'h0000_37FF);
    sec_cp10_dis = 0;
    reg_read(2, 1, d, u, h);
    check("R5 raw bits unchanged", d, 32'h0000_33FF);
  endtask

  task automatic t_pair();
    logic [2:0] c;
    reg_write(32'h0000_0C00, 2, 1);
    req_cls(2, 1, 1, 1, 1, c);
    check("R9 pair traps simd kernel", {29'd0, c}, 3'b010);
    req_cls(2, 2, 1, 1, 1, c);
    check("R9 pair simd hyp undef", {29'd0, c}, 3'b100);
    reg_write(32'h0000_0400, 2, 1);
    req_cls(2, 1, 1, 1, 1, c);
    check("R9 single cp no simd trap", {29'd0, c}, 3'b001);
  endtask

  task automatic t_acr();
    logic [2:0] c;
    reg_write(32'h8000_0000, 2, 1);
    req_cls(3, 1, 1, 1, 1, c);
    check("R10 acr kernel trap", {29'd0, c}, 3'b010);
    req_cls(3, 0, 1, 1, 1, c);
    check("R10 acr user allow", {29'd0, c}, 3'b001);
    req_cls(3, 2, 1, 1, 1, c);
    check("R10 acr hyp allow", {29'd0, c}, 3'b001);
  endtask

  // Full sweep for several register settings; R6/R7/R8/R11 by model.
  task automatic t_sweep();
    logic [2:0] c;
    logic [31:0] words [4] = '{32'h0, 32'h0000_8000, 32'h0000_0800, 32'h8000_8C00};
    for (int w = 0; w < 4; w++) begin
      reg_write(words[w], 2, 1);
      for (int f = 0; f < 4; f++)
        for (int el = 0; el < 4; el++)
          for (int k = 0; k < 8; k++) begin
            req_cls(f, el, k[0], k[1], k[2], c);
            check((el == 2) ? "R8 sweep" : ((k == 7 && el < 2) ? "R7 sweep" : "R11 sweep"),
                  {29'd0, c},
                  {29'd0, model_cls(f, el, k[0], k[1], k[2], words[w][31],
                                    words[w][15], words[w][11], words[w][10])});
            check("R6 onehot", $countones(c), 1);
          end
    end
    fq_valid = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_decode();
    t_priv();
    t_write();
    t_merge();
    t_pair();
    t_acr();
    t_sweep();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule